// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A single general-purpose I/O port of up to sixteen pins, reached through a small word-addressed 32-bit register interface. Every pin has a direction bit, an output latch and an input value that passes through a two-flop synchronizer. A pin can raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. Each pin has its own enable, latched status, mask and write-one-to-clear control. The unmasked status bits are combined into one interrupt line.

Software selects a pin's trigger by writing a 4-bit slot in one of two mode words. It enables the pin and clears any stale status. Masking is changed through separate set and clear words, so no read-modify-write is needed. A soft-reset word forces every port register to its default while it holds 1. The port then resumes once that word is written back to 0.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, direction, output latch, enable, status and every mode slot are 0. The mask is all ones over the implemented pins. `irq_o` and `pin_oe_o` are 0.
- R2: `pin_oe_o` follows the direction word (offset 8, 1 = output). `pin_o` follows the output word (offset 6). Data bits above the pin count are dropped and read back as 0.
- R3: The input word (offset 7) returns `pin_i` after two rising clock edges of synchronization.
- R4: Trigger code 1 in a pin's slot sets its status on a rising input and code 0 on a falling input. The status bit reads 1 after the third clock edge that follows the pin change, and not before. Status is at offset 1.
- R5: Trigger code 4 sets status on both rising and falling inputs.
- R6: Code 3 (high level) and code 2 (low level) set status on every cycle the level holds. A clear issued while the level persists leaves the bit set.
- R7: A pin with enable 0 (enable word at offset 0), or with slot code 5, 6 or 7, never sets status.
- R8: Writing 1 to a bit of the clear word (offset 3) clears that status bit. Bits written 0 are unaffected. A new trigger in the same cycle wins over the clear. The clear word reads 0.
- R9: Writing 1 to a bit of the mask-set word (offset 4) masks that pin, and writing 1 to the mask-clear word (offset 5) unmasks it. Bits written 0 have no effect. Offset 4 reads the current mask and offset 5 reads 0.
- R10: The display word (offset 2) reads status AND NOT mask. `irq_o` is 1 exactly when any display bit is 1.
- R11: Pin p < 8 has its slot in mode word 0 (offset 9) at bits 4p+3..4p. Pin p >= 8 has its slot in mode word 1 (offset 10) at bits 4(p-8)+3..4(p-8).
- R12: Writing 1 to bit 0 of the soft-reset word (offset 15) holds all port registers at their R1 defaults and ignores writes to them. Writing 0 releases them. Offset 15 reads the held flag in bit 0.
- R13: Offset 11 and the unused offsets 12 to 14 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | Write enable, qualifies req_i |
| addr_i | input | 4 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NPINS | Pin levels, asynchronous |
| pin_o | output | NPINS | Output latch |
| pin_oe_o | output | NPINS | Output enable per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that the bus inputs are synchronous to `clk_i` and have known values whenever `rst_ni` is high. A write is taken as a single-cycle `req_i && we_i` pulse. The assertions place no timing assumption on `pin_i`, since the synchronizer absorbs its asynchrony. The stimulus changes bus signals and pins only at falling clock edges, spaces its writes two cycles apart, and reads back combinationally half a cycle after the edge under test.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW   = 4;
  localparam int SLOT_W   = 4;
  localparam int SLOTS_PR = 8;

  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_IEN   = 4'd0;
  localparam reg_addr_t A_STAT  = 4'd1;
  localparam reg_addr_t A_DISP  = 4'd2;
  localparam reg_addr_t A_CLR   = 4'd3;
  localparam reg_addr_t A_MSET  = 4'd4;
  localparam reg_addr_t A_MCLR  = 4'd5;
  localparam reg_addr_t A_OUT   = 4'd6;
  localparam reg_addr_t A_IN    = 4'd7;
  localparam reg_addr_t A_DIR   = 4'd8;
  localparam reg_addr_t A_MODE0 = 4'd9;
  localparam reg_addr_t A_MODE1 = 4'd10;
  localparam reg_addr_t A_SRST  = 4'd15;

  typedef enum logic [2:0] {
    TRG_FALL = 3'd0,
    TRG_RISE = 3'd1,
    TRG_LOW  = 3'd2,
    TRG_HIGH = 3'd3,
    TRG_BOTH = 3'd4
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  output logic       hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    case (mode_i)
      TRG_FALL: hit_o = prev_q & ~lvl_i;
      TRG_RISE: hit_o = ~prev_q & lvl_i;
      TRG_LOW:  hit_o = ~lvl_i;
      TRG_HIGH: hit_o = lvl_i;
      TRG_BOTH: hit_o = prev_q ^ lvl_i;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16,
  localparam int MW = NPINS * SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [NPINS-1:0] pin_sync_i,
  input  logic [NPINS-1:0] hit_i,
  output logic [NPINS-1:0] ien_o,
  output logic [NPINS-1:0] stat_o,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] out_o,
  output logic [NPINS-1:0] dir_o,
  output logic [MW-1:0]    mode_o,
  output logic             srst_o
);
  logic             wr;
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] clr_w;
  logic             srst_q;
  logic [NPINS-1:0] ien_q, stat_q, mask_q, out_q, dir_q;
  logic [SLOT_W-1:0] mode_q [NPINS];
  logic [31:0]      mode_w0, mode_w1;

  assign wr    = req_i & we_i;
  assign wd    = wdata_i[NPINS-1:0];
  assign clr_w = (wr && addr_i == A_CLR) ? wd : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q <= 1'b0;
      ien_q  <= '0;
      stat_q <= '0;
      mask_q <= '1;
      out_q  <= '0;
      dir_q  <= '0;
      for (int p = 0; p < NPINS; p++) mode_q[p] <= '0;
    end else begin
      if (wr && addr_i == A_SRST) srst_q <= wdata_i[0];
      if (srst_q) begin
        ien_q  <= '0;
        stat_q <= '0;
        mask_q <= '1;
        out_q  <= '0;
        dir_q  <= '0;
        for (int p = 0; p < NPINS; p++) mode_q[p] <= '0;
      end else begin
        // new trigger wins over a same-cycle clear
        stat_q <= (stat_q & ~clr_w) | (hit_i & ien_q);
        if (wr) begin
          case (addr_i)
            A_IEN:   ien_q  <= wd;
            A_MSET:  mask_q <= mask_q | wd;
            A_MCLR:  mask_q <= mask_q & ~wd;
            A_OUT:   out_q  <= wd;
            A_DIR:   dir_q  <= wd;
            default: ;
          endcase
        end
        for (int p = 0; p < NPINS; p++) begin
          if (wr && addr_i == ((p < SLOTS_PR) ? A_MODE0 : A_MODE1))
            mode_q[p] <= wdata_i[SLOT_W*(p%SLOTS_PR) +: SLOT_W];
        end
      end
    end
  end

  always_comb begin
    mode_w0 = '0;
    mode_w1 = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (p < SLOTS_PR) mode_w0[SLOT_W*(p%SLOTS_PR) +: SLOT_W] = mode_q[p];
      else              mode_w1[SLOT_W*(p%SLOTS_PR) +: SLOT_W] = mode_q[p];
    end
  end

  always_comb begin
    case (addr_i)
      A_IEN:   rdata_o = 32'(ien_q);
      A_STAT:  rdata_o = 32'(stat_q);
      A_DISP:  rdata_o = 32'(stat_q & ~mask_q);
      A_MSET:  rdata_o = 32'(mask_q);
      A_OUT:   rdata_o = 32'(out_q);
      A_IN:    rdata_o = 32'(pin_sync_i);
      A_DIR:   rdata_o = 32'(dir_q);
      A_MODE0: rdata_o = mode_w0;
      A_MODE1: rdata_o = mode_w1;
      A_SRST:  rdata_o = {31'd0, srst_q};
      default: rdata_o = '0;
    endcase
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_mode_out
    assign mode_o[SLOT_W*p +: SLOT_W] = mode_q[p];
  end

  assign ien_o  = ien_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign srst_o = srst_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe_o,
  output logic             irq_o
);
  localparam int MW = NPINS * SLOT_W;

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] ien, stat, mask;
  logic [MW-1:0]    mode;
  logic             srst;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_det
    gpio_trig_det u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pin_sync[p]),
      .mode_i(mode[SLOT_W*p +: 3]),
      .hit_o (hit[p])
    );
  end

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_sync_i(pin_sync),
    .hit_i     (hit),
    .ien_o     (ien),
    .stat_o    (stat),
    .mask_o    (mask),
    .out_o     (pin_o),
    .dir_o     (pin_oe_o),
    .mode_o    (mode),
    .srst_o    (srst)
  );

  assign irq_o = |(stat & ~mask);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [3:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic [NPINS-1:0] pin_oe_o,
  input logic             irq_o,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] ien,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] mask,
  input logic             srst
);
  logic wr;
  assign wr = req_i & we_i;

  AST_STAT_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & ~$past(stat) & ~$past(hit & ien)) == '0)); // R7

  AST_CLR_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_CLR && !srst) |=>
      ((stat & $past(wdata_i[NPINS-1:0] & ~(hit & ien))) == '0)); // R8

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_MSET && !srst) |=>
      ((mask & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0]))); // R9

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == A_DIR && !srst) |=> (pin_oe_o == $past(wdata_i[NPINS-1:0]))); // R2

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> !irq_o); // R10

  AST_SRST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (ien == '0 && pin_oe_o == '0 && (&mask) && !irq_o)); // R12
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_oe_o(pin_oe_o),
  .irq_o   (irq_o),
  .hit     (hit),
  .ien     (ien),
  .stat    (stat),
  .mask    (mask),
  .srst    (srst)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;

  localparam logic [3:0] O_IEN = 4'd0, O_STAT = 4'd1, O_DISP = 4'd2, O_CLR = 4'd3;
  localparam logic [3:0] O_MSET = 4'd4, O_MCLR = 4'd5, O_OUT = 4'd6, O_IN = 4'd7;
  localparam logic [3:0] O_DIR = 4'd8, O_MODE0 = 4'd9, O_MODE1 = 4'd10, O_RSV = 4'd11;
  localparam logic [3:0] O_SRST = 4'd15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pout, poe;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port #(.NPINS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [NP-1:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic quiesce();
    wr(O_IEN, 32'h0);
    wr(O_CLR, 32'hFFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 oe", 32'(poe), 0);
    rd(O_IEN, d);   chk("R1 ien", d, 0);
    rd(O_STAT, d);  chk("R1 stat", d, 0);
    rd(O_MSET, d);  chk("R1 mask", d, 32'hFFFF);
    rd(O_DIR, d);   chk("R1 dir", d, 0);
    rd(O_OUT, d);   chk("R1 out", d, 0);
    rd(O_MODE0, d); chk("R1 mode0", d, 0);
    rd(O_MODE1, d); chk("R1 mode1", d, 0);
    rd(O_RSV, d);   chk("R13 reserved", d, 0);
    rd(4'd13, d);   chk("R13 unused", d, 0);
    rd(O_CLR, d);   chk("R8 clr reads 0", d, 0);
  endtask

  task automatic t_dir_out();
    logic [31:0] d;
    wr(O_DIR, 32'h0000_00F0);
    wr(O_OUT, 32'hFFFF_A5A5);
    chk("R2 pin_oe", 32'(poe), 32'h00F0);
    chk("R2 pin_o", 32'(pout), 32'hA5A5);
    rd(O_OUT, d); chk("R2 out upper dropped", d, 32'hA5A5);
    wr(O_DIR, 32'h0);
    wr(O_OUT, 32'h0);
    chk("R2 pin_oe cleared", 32'(poe), 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    set_pins(16'h1234);
    tick(1); rd_now(O_IN, d); chk("R3 not yet", d, 0);
    tick(1); rd_now(O_IN, d); chk("R3 synced", d, 32'h1234);
    set_pins(16'h0);
    tick(4);
    rd_now(O_IN, d); chk("R3 back to zero", d, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(O_MODE0, 32'h0000_1000);
    rd(O_MODE0, d); chk("R11 pin3 slot", d, 32'h1000);
    wr(O_IEN, 32'h8);
    set_pins(16'h0008);
    tick(2); rd_now(O_STAT, d); chk("R4 rise before 3rd edge", d, 0);
    tick(1); rd_now(O_STAT, d); chk("R4 rise at 3rd edge", d, 32'h8);
    chk("R10 irq on", 32'(irq), 1);
    wr(O_CLR, 32'h8);
    rd(O_STAT, d); chk("R8 cleared", d, 0);
    set_pins(16'h0);
    tick(4); rd_now(O_STAT, d); chk("R4 fall ignored in rise mode", d, 0);
    quiesce();
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(O_MODE1, 32'h0);
    set_pins(16'h0200);
    tick(4);
    wr(O_IEN, 32'h200);
    rd(O_STAT, d); chk("R4 high held no fall", d, 0);
    set_pins(16'h0);
    tick(4); rd_now(O_STAT, d); chk("R4 fall pin9", d, 32'h200);
    quiesce();
  endtask

  task automatic t_both();
    logic [31:0] d;
    wr(O_MODE1, 32'h0004_0000);
    rd(O_MODE1, d); chk("R11 pin12 slot", d, 32'h0004_0000);
    wr(O_IEN, 32'h1000);
    set_pins(16'h1000);
    tick(4); rd_now(O_STAT, d); chk("R5 both rise", d, 32'h1000);
    wr(O_CLR, 32'h1000);
    rd(O_STAT, d); chk("R5 cleared", d, 0);
    set_pins(16'h0);
    tick(4); rd_now(O_STAT, d); chk("R5 both fall", d, 32'h1000);
    quiesce();
    wr(O_MODE1, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(O_MODE0, 32'h0000_0003);
    wr(O_IEN, 32'h1);
    tick(3); rd_now(O_STAT, d); chk("R6 high not met", d, 0);
    set_pins(16'h0001);
    tick(4); rd_now(O_STAT, d); chk("R6 high set", d, 32'h1);
    wr(O_CLR, 32'h1);
    rd(O_STAT, d); chk("R6 clear while level held", d, 32'h1);
    set_pins(16'h0);
    tick(4);
    wr(O_CLR, 32'h1);
    rd(O_STAT, d); chk("R6 cleared after level gone", d, 0);
    wr(O_MODE0, 32'h0000_0020);
    wr(O_IEN, 32'h2);
    rd(O_STAT, d); chk("R6 low level set", d, 32'h2);
    quiesce();
    rd(O_STAT, d); chk("R6 low cleared when disabled", d, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(O_MODE0, 32'h0003_0500);
    wr(O_IEN, 32'h4);
    set_pins(16'h0014);
    tick(4); rd_now(O_STAT, d); chk("R7 code5 and disabled high", d, 0);
    set_pins(16'h0000);
    tick(4); rd_now(O_STAT, d); chk("R7 code5 fall", d, 0);
    wr(O_MODE0, 32'h0000_0700);
    set_pins(16'h0004);
    tick(4); rd_now(O_STAT, d); chk("R7 code7 rise", d, 0);
    set_pins(16'h0);
    quiesce();
    wr(O_MODE0, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(O_MODE0, 32'h0000_1000);
    wr(O_IEN, 32'h8);
    set_pins(16'h0008);
    tick(4);
    rd_now(O_STAT, d); chk("R4 status for mask test", d, 32'h8);
    wr(O_CLR, 32'h0);
    rd(O_STAT, d); chk("R8 zero write no effect", d, 32'h8);
    wr(O_CLR, 32'h4);
    rd(O_STAT, d); chk("R8 other bit no effect", d, 32'h8);
    wr(O_MSET, 32'h0);
    chk("R9 mset zero no effect", 32'(irq), 1);
    wr(O_MSET, 32'h8);
    chk("R10 masked irq", 32'(irq), 0);
    rd(O_DISP, d); chk("R10 disp masked", d, 0);
    rd(O_STAT, d); chk("R10 stat kept", d, 32'h8);
    rd(O_MSET, d); chk("R9 mask readback", d, 32'h8);
    rd(O_MCLR, d); chk("R9 mclr reads 0", d, 0);
    wr(O_MCLR, 32'h8);
    chk("R9 unmask irq", 32'(irq), 1);
    rd(O_DISP, d); chk("R10 disp shows", d, 32'h8);
    wr(O_CLR, 32'h8);
    chk("R10 irq drops", 32'(irq), 0);
    set_pins(16'h0);
    quiesce();
    wr(O_MODE0, 32'h0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    wr(O_DIR, 32'h0F0F);
    wr(O_OUT, 32'h3);
    wr(O_IEN, 32'h1);
    wr(O_MODE1, 32'h3);
    wr(O_SRST, 32'h1);
    rd(O_DIR, d); chk("R12 dir default", d, 0);
    chk("R12 oe default", 32'(poe), 0);
    chk("R12 pin_o default", 32'(pout), 0);
    rd(O_IEN, d); chk("R12 ien default", d, 0);
    rd(O_MSET, d); chk("R12 mask default", d, 32'hFFFF);
    rd(O_MODE1, d); chk("R12 mode default", d, 0);
    rd(O_SRST, d); chk("R12 flag reads 1", d, 1);
    wr(O_DIR, 32'hFF);
    wr(O_SRST, 32'h0);
    rd(O_SRST, d); chk("R12 flag reads 0", d, 0);
    rd(O_DIR, d); chk("R12 write ignored while held", d, 0);
    wr(O_DIR, 32'h5);
    rd(O_DIR, d); chk("R12 released", d, 32'h5);
    wr(O_DIR, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_dir_out();
    t_input();
    wr(O_MCLR, 32'hFFFF);
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_ignored();
    t_mask();
    t_srst();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule